// File: doc/BRIEF.md
# Qualified Trace Capture Buffer

This block records processor bus samples into a circular on-chip memory for later inspection. Each incoming sample is 80 bits wide and carries address, data, control, port and probe lines. When the block stores a sample, it writes it together with a 16-bit timestamp. The timestamp counts time-base ticks since the previous stored entry and saturates rather than wrapping. Three conditions must all hold for a sample to be stored: the sample is valid, the trace-enable input is high, and the sample's cycle type matches a qualifier mask. An optional inclusive address window can narrow storage further.

A trigger input starts the post-trigger phase while the processor keeps running. After a number of further stored samples programmed at arm time, the write pointer freezes and the capture is marked done. The part of the buffer that is left therefore holds the pre-trigger history. After the freeze, a readout request streams every stored entry out in order, oldest first, one per cycle. A full flag shows whether the buffer has wrapped at least once.

Top module: `trace_capture_buf`

## Requirements
- R1: A sample is stored only in a cycle where capture is recording, `smp_valid_i` and `trace_en_i` are high, and `smp_kind_i & qual_mask_i` is non-zero. Kind bit 0 marks a read, bit 1 a write, bit 2 an instruction fetch and bit 3 the first opcode byte.
- R2: When `rng_en_i` is high, a sample is stored only if its address is inside the inclusive window `rng_lo_i..rng_hi_i`. The address is `smp_data_i[ADDR_LSB +: ADDR_W]`, which is bits 15:0 by default. When `rng_en_i` is low, the address plays no part.
- R3: Each entry carries a time delta. It counts the `tick_i` pulses seen from the previous store cycle (inclusive) up to the current store cycle (exclusive). For the first entry after arming, counting starts in the cycle after arming. The delta saturates at 0xFFFF.
- R4: The first `trig_i` pulse while recording starts the post-trigger phase. A sample stored in that same cycle counts as pre-trigger. After `post_cnt_i` (latched at arm) more stored samples, recording stops and `done_o` rises in the cycle of the last of them.
- R5: With a latched post count of zero, recording stops in the trigger cycle itself. A sample stored in that cycle is kept.
- R6: Once `done_o` is high, no further sample is stored, whatever the inputs.
- R7: `full_o` rises when a store wraps the write pointer past the last location. It stays high until the next arm.
- R8: A `rd_start_i` pulse while done streams the entries out. Without a wrap, the entries are those written from location 0. After a wrap, all DEPTH entries are streamed, starting at the frozen write pointer. The first `rd_valid_o` comes two clock edges after the request, one entry per cycle follows, and `rd_last_o` marks the final entry.
- R9: Reset leaves the block idle, with `recording_o`, `done_o`, `full_o` and `rd_valid_o` low. An `arm_i` pulse clears the pointer, full, done, trigger and delta state and starts recording.
- R10: `arm_i` and `rd_start_i` are ignored while a readout is in progress. The capture stays done and the stream completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| arm_i | input | 1 | Start a new capture |
| post_cnt_i | input | log2(DEPTH) | Post-trigger stored-sample count, latched on arm |
| trace_en_i | input | 1 | Trace on/off gate |
| qual_mask_i | input | 4 | Cycle types to keep |
| rng_en_i | input | 1 | Enable address window |
| rng_lo_i | input | ADDR_W | Window low bound (inclusive) |
| rng_hi_i | input | ADDR_W | Window high bound (inclusive) |
| smp_valid_i | input | 1 | Sample present this cycle |
| smp_kind_i | input | 4 | Cycle type of the sample |
| smp_data_i | input | SAMPLE_W | Bus sample |
| tick_i | input | 1 | Time-base tick |
| trig_i | input | 1 | Trace trigger |
| rd_start_i | input | 1 | Begin readout |
| recording_o | output | 1 | Capture active |
| done_o | output | 1 | Capture frozen |
| full_o | output | 1 | Buffer has wrapped |
| rd_valid_o | output | 1 | Readout entry valid |
| rd_last_o | output | 1 | Final readout entry |
| rd_data_o | output | SAMPLE_W | Readout sample |
| rd_dt_o | output | TS_W | Readout time delta |

## Verification
A trigger and a qualified store can fall in the same cycle. The bench provokes this by pulsing `trig_i` together with a valid, qualified sample. It does so once with a non-zero post count and once with a post count of zero. In both cases the reference model expects that sample in the readout as the last pre-trigger entry. With a zero count it is also the final entry, and `done_o` is expected high right after that edge. An arm request landing in the middle of a wrapped readout is the second collision. It is judged by the full 16-entry stream arriving intact, with `done_o` still high afterwards.

// File: rtl/tcb_pkg.sv
package tcb_pkg;
   localparam int KIND_W = 4;

   typedef enum logic [1:0] {
      CAP_IDLE = 2'd0,
      CAP_REC  = 2'd1,
      CAP_DONE = 2'd2
   } cap_state_e;
endpackage

// File: rtl/tcb_qualify.sv
module tcb_qualify #(
   parameter int KIND_W   = 4,
   parameter int ADDR_W   = 16,
   parameter bit RANGE_EN = 1'b1
) (
   input  logic [KIND_W-1:0] kind_i,
   input  logic [KIND_W-1:0] mask_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              rng_en_i,
   input  logic [ADDR_W-1:0] lo_i,
   input  logic [ADDR_W-1:0] hi_i,
   output logic              hit_o
);
   logic kind_ok;
   logic win_ok;

   assign kind_ok = |(kind_i & mask_i);

   generate
      if (RANGE_EN) begin : g_window
         assign win_ok = !rng_en_i || ((addr_i >= lo_i) && (addr_i <= hi_i));
      end else begin : g_no_window
         logic unused_win;
         assign unused_win = &{1'b0, rng_en_i, addr_i, lo_i, hi_i};
         assign win_ok = 1'b1;
      end
   endgenerate

   assign hit_o = kind_ok && win_ok;
endmodule

// File: rtl/tcb_delta.sv
module tcb_delta #(
   parameter int TS_W = 16
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            clear_i,
   input  logic            store_i,
   input  logic            tick_i,
   output logic [TS_W-1:0] dt_o
);
   localparam logic [TS_W-1:0] TS_MAX = '1;

   logic [TS_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (clear_i) begin
         cnt_q <= '0;
      end else if (store_i) begin
         cnt_q <= {{(TS_W-1){1'b0}}, tick_i};
      end else if (tick_i && (cnt_q != TS_MAX)) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign dt_o = cnt_q;
endmodule

// File: rtl/tcb_ram.sv
module tcb_ram #(
   parameter int W     = 96,
   parameter int DEPTH = 1024,
   localparam int AW   = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          we_i,
   input  logic [AW-1:0] waddr_i,
   input  logic [W-1:0]  wdata_i,
   input  logic          re_i,
   input  logic [AW-1:0] raddr_i,
   output logic [W-1:0]  rdata_o
);
   logic [W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we_i) mem[waddr_i] <= wdata_i;
      if (re_i) rdata_o <= mem[raddr_i];
   end
endmodule

// File: rtl/trace_capture_buf.sv
module trace_capture_buf #(
   parameter int SAMPLE_W = 80,
   parameter int TS_W     = 16,
   parameter int DEPTH    = 1024,
   parameter int ADDR_W   = 16,
   parameter int ADDR_LSB = 0,
   parameter bit RANGE_EN = 1'b1,
   localparam int PTR_W   = $clog2(DEPTH),
   localparam int KIND_W  = tcb_pkg::KIND_W
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                arm_i,
   input  logic [PTR_W-1:0]    post_cnt_i,
   input  logic                trace_en_i,
   input  logic [KIND_W-1:0]   qual_mask_i,
   input  logic                rng_en_i,
   input  logic [ADDR_W-1:0]   rng_lo_i,
   input  logic [ADDR_W-1:0]   rng_hi_i,
   input  logic                smp_valid_i,
   input  logic [KIND_W-1:0]   smp_kind_i,
   input  logic [SAMPLE_W-1:0] smp_data_i,
   input  logic                tick_i,
   input  logic                trig_i,
   input  logic                rd_start_i,
   output logic                recording_o,
   output logic                done_o,
   output logic                full_o,
   output logic                rd_valid_o,
   output logic                rd_last_o,
   output logic [SAMPLE_W-1:0] rd_data_o,
   output logic [TS_W-1:0]     rd_dt_o
);
   import tcb_pkg::*;

   localparam int ENT_W = SAMPLE_W + TS_W;
   localparam int CNT_W = PTR_W + 1;

   generate
      if ((1 << PTR_W) != DEPTH || DEPTH < 2) begin : g_bad_depth
         $error("DEPTH must be a power of two of at least 2");
      end
      if (ADDR_LSB + ADDR_W > SAMPLE_W) begin : g_bad_addr
         $error("address field lies outside the sample");
      end
      if (TS_W < 2) begin : g_bad_ts
         $error("TS_W must be at least 2");
      end
   endgenerate

   cap_state_e       st_q;
   logic             trig_seen_q;
   logic [PTR_W-1:0] post_cfg_q;
   logic [PTR_W-1:0] post_left_q;
   logic [PTR_W-1:0] wp_q;
   logic             full_q;

   logic             hit;
   logic             store;
   logic             arm_ok;
   logic [TS_W-1:0]  dt_cur;

   logic             rd_busy;
   logic [PTR_W-1:0] rd_ptr_q;
   logic [CNT_W-1:0] rd_left_q;
   logic             rd_valid_q;
   logic             rd_last_q;
   logic             rd_go;
   logic [ENT_W-1:0] rd_q;

   tcb_qualify #(
      .KIND_W   (KIND_W),
      .ADDR_W   (ADDR_W),
      .RANGE_EN (RANGE_EN)
   ) u_qual (
      .kind_i   (smp_kind_i),
      .mask_i   (qual_mask_i),
      .addr_i   (smp_data_i[ADDR_LSB +: ADDR_W]),
      .rng_en_i (rng_en_i),
      .lo_i     (rng_lo_i),
      .hi_i     (rng_hi_i),
      .hit_o    (hit)
   );

   assign arm_ok = arm_i && !rd_busy;
   assign store  = (st_q == CAP_REC) && smp_valid_i && trace_en_i && hit;

   tcb_delta #(.TS_W(TS_W)) u_delta (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear_i (arm_ok),
      .store_i (store),
      .tick_i  (tick_i),
      .dt_o    (dt_cur)
   );

   // capture control: pointer, wrap flag, trigger and post-trigger count
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q        <= CAP_IDLE;
         trig_seen_q <= 1'b0;
         post_cfg_q  <= '0;
         post_left_q <= '0;
         wp_q        <= '0;
         full_q      <= 1'b0;
      end else if (arm_ok) begin
         st_q        <= CAP_REC;
         trig_seen_q <= 1'b0;
         post_cfg_q  <= post_cnt_i;
         post_left_q <= '0;
         wp_q        <= '0;
         full_q      <= 1'b0;
      end else begin
         if (store) begin
            wp_q <= wp_q + 1'b1;
            if (wp_q == {PTR_W{1'b1}}) full_q <= 1'b1;
         end
         if (st_q == CAP_REC) begin
            if (!trig_seen_q && trig_i) begin
               trig_seen_q <= 1'b1;
               post_left_q <= post_cfg_q;
               if (post_cfg_q == '0) st_q <= CAP_DONE;
            end else if (trig_seen_q && store) begin
               post_left_q <= post_left_q - 1'b1;
               if (post_left_q == PTR_W'(1)) st_q <= CAP_DONE;
            end
         end
      end
   end

   // readout sequencing: oldest entry first, one per cycle
   assign rd_go = rd_start_i && !arm_i && !rd_busy && (st_q == CAP_DONE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_busy    <= 1'b0;
         rd_ptr_q   <= '0;
         rd_left_q  <= '0;
         rd_valid_q <= 1'b0;
         rd_last_q  <= 1'b0;
      end else begin
         rd_valid_q <= rd_busy;
         rd_last_q  <= rd_busy && (rd_left_q == CNT_W'(1));
         if (rd_go) begin
            rd_ptr_q  <= full_q ? wp_q : '0;
            rd_left_q <= full_q ? CNT_W'(DEPTH) : {1'b0, wp_q};
            rd_busy   <= full_q || (wp_q != '0);
         end else if (rd_busy) begin
            rd_ptr_q  <= rd_ptr_q + 1'b1;
            rd_left_q <= rd_left_q - 1'b1;
            if (rd_left_q == CNT_W'(1)) rd_busy <= 1'b0;
         end
      end
   end

   tcb_ram #(.W(ENT_W), .DEPTH(DEPTH)) u_ram (
      .clk     (clk),
      .we_i    (store),
      .waddr_i (wp_q),
      .wdata_i ({dt_cur, smp_data_i}),
      .re_i    (rd_busy),
      .raddr_i (rd_ptr_q),
      .rdata_o (rd_q)
   );

   assign recording_o = (st_q == CAP_REC);
   assign done_o      = (st_q == CAP_DONE);
   assign full_o      = full_q;
   assign rd_valid_o  = rd_valid_q;
   assign rd_last_o   = rd_last_q;
   assign rd_data_o   = rd_q[SAMPLE_W-1:0];
   assign rd_dt_o     = rd_q[ENT_W-1:SAMPLE_W];
endmodule

// File: rtl/tcb_checker.sv
module tcb_checker (
   input logic clk,
   input logic rst_n,
   input logic arm_i,
   input logic recording_o,
   input logic done_o,
   input logic full_o,
   input logic rd_valid_o,
   input logic rd_last_o,
   input logic rd_busy
);
   p_done_holds_r4: assert property (@(posedge clk) disable iff (!rst_n)
      done_o && !(arm_i && !rd_busy) |=> done_o);

   p_stop_via_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(recording_o) |-> done_o);

   p_full_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
      full_o && !(arm_i && !rd_busy) |=> full_o);

   p_rd_when_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid_o |-> done_o);

   p_last_ends_r8: assert property (@(posedge clk) disable iff (!rst_n)
      rd_last_o |=> !rd_valid_o);

   p_last_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
      rd_last_o |-> rd_valid_o);

   p_arm_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
      arm_i && !rd_busy |=> recording_o && !done_o && !full_o);

   p_arm_blocked_r10: assert property (@(posedge clk) disable iff (!rst_n)
      arm_i && rd_busy |=> done_o && !recording_o);
endmodule

bind trace_capture_buf tcb_checker u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .arm_i       (arm_i),
   .recording_o (recording_o),
   .done_o      (done_o),
   .full_o      (full_o),
   .rd_valid_o  (rd_valid_o),
   .rd_last_o   (rd_last_o),
   .rd_busy     (rd_busy)
);

// File: tb/sim_trace_capture_buf.sv
module sim_trace_capture_buf;
   localparam int CLK_PERIOD = 10;
   localparam int DEPTH_T    = 16;
   localparam int PW         = $clog2(DEPTH_T);
   localparam int SW         = 80;
   localparam int TW         = 16;
   localparam int AW         = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          arm_i = 1'b0;
   logic [PW-1:0] post_cnt_i = '0;
   logic          trace_en_i = 1'b0;
   logic [3:0]    qual_mask_i = '0;
   logic          rng_en_i = 1'b0;
   logic [AW-1:0] rng_lo_i = '0;
   logic [AW-1:0] rng_hi_i = '0;
   logic          smp_valid_i = 1'b0;
   logic [3:0]    smp_kind_i = '0;
   logic [SW-1:0] smp_data_i = '0;
   logic          tick_i = 1'b0;
   logic          trig_i = 1'b0;
   logic          rd_start_i = 1'b0;
   logic          recording_o, done_o, full_o, rd_valid_o, rd_last_o;
   logic [SW-1:0] rd_data_o;
   logic [TW-1:0] rd_dt_o;

   always #(CLK_PERIOD/2) clk = ~clk;

   trace_capture_buf #(.DEPTH(DEPTH_T)) u0 (
      .clk(clk), .rst_n(rst_n), .arm_i(arm_i), .post_cnt_i(post_cnt_i),
      .trace_en_i(trace_en_i), .qual_mask_i(qual_mask_i), .rng_en_i(rng_en_i),
      .rng_lo_i(rng_lo_i), .rng_hi_i(rng_hi_i), .smp_valid_i(smp_valid_i),
      .smp_kind_i(smp_kind_i), .smp_data_i(smp_data_i), .tick_i(tick_i),
      .trig_i(trig_i), .rd_start_i(rd_start_i), .recording_o(recording_o),
      .done_o(done_o), .full_o(full_o), .rd_valid_o(rd_valid_o),
      .rd_last_o(rd_last_o), .rd_data_o(rd_data_o), .rd_dt_o(rd_dt_o)
   );

   int checks = 0;
   int errors = 0;
   string cur_tag = "R8";

   typedef struct packed {
      logic [SW-1:0] d;
      logic [TW-1:0] t;
      logic          last;
   } exp_t;
   exp_t exp_q[$];

   // reference model, built from the requirements
   logic          m_rec, m_done, m_trig, m_full;
   logic [PW-1:0] m_wp, m_post_cfg, m_post_left;
   logic [TW-1:0] m_dt;
   logic [SW-1:0] m_data [DEPTH_T];
   logic [TW-1:0] m_ts   [DEPTH_T];

   task automatic chk(input bit ok, input string req, input logic [95:0] act, input logic [95:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic model_step(input logic v, input logic [3:0] k, input logic [SW-1:0] d,
                             input logic tk, input logic tg);
      logic [AW-1:0] a;
      logic hit, st;
      a   = d[AW-1:0];
      hit = v && trace_en_i && ((k & qual_mask_i) != 4'd0) &&
            (!rng_en_i || ((a >= rng_lo_i) && (a <= rng_hi_i)));
      st  = m_rec && hit;
      if (st) begin
         m_data[m_wp] = d;
         m_ts[m_wp]   = m_dt;
         if (m_wp == PW'(DEPTH_T-1)) m_full = 1'b1;
         m_wp = m_wp + 1'b1;
      end
      if (st) m_dt = {15'd0, tk};
      else if (tk && m_dt != 16'hFFFF) m_dt = m_dt + 1'b1;
      if (m_rec) begin
         if (!m_trig && tg) begin
            m_trig = 1'b1;
            m_post_left = m_post_cfg;
            if (m_post_cfg == '0) begin m_rec = 1'b0; m_done = 1'b1; end
         end else if (m_trig && st) begin
            m_post_left = m_post_left - 1'b1;
            if (m_post_left == '0) begin m_rec = 1'b0; m_done = 1'b1; end
         end
      end
   endtask

   task automatic idle_inputs();
      arm_i = 1'b0; smp_valid_i = 1'b0; smp_kind_i = '0; smp_data_i = '0;
      tick_i = 1'b0; trig_i = 1'b0; rd_start_i = 1'b0;
   endtask

   task automatic arm(input logic [PW-1:0] post);
      @(negedge clk);
      arm_i = 1'b1; post_cnt_i = post;
      m_rec = 1'b1; m_done = 1'b0; m_trig = 1'b0; m_full = 1'b0;
      m_wp = '0; m_post_cfg = post; m_post_left = '0; m_dt = '0;
      @(negedge clk);
      idle_inputs();
   endtask

   task automatic drive(input logic v, input logic [3:0] k, input logic [SW-1:0] d,
                        input logic tk, input logic tg);
      @(negedge clk);
      smp_valid_i = v; smp_kind_i = k; smp_data_i = d; tick_i = tk; trig_i = tg;
      model_step(v, k, d, tk, tg);
      @(negedge clk);
      idle_inputs();
   endtask

   task automatic tick_run(input int n);
      @(negedge clk);
      tick_i = 1'b1;
      repeat (n) @(negedge clk);
      tick_i = 1'b0;
      for (int i = 0; i < n; i++) if (m_dt != 16'hFFFF) m_dt = m_dt + 1'b1;
   endtask

   task automatic readout(input bit arm_mid);
      int n;
      n = m_full ? DEPTH_T : int'(m_wp);
      for (int i = 0; i < n; i++) begin
         logic [PW-1:0] idx;
         exp_t e;
         idx = m_full ? PW'(int'(m_wp) + i) : PW'(i);
         e.d = m_data[idx]; e.t = m_ts[idx]; e.last = (i == n-1);
         exp_q.push_back(e);
      end
      @(negedge clk);
      rd_start_i = 1'b1;
      @(negedge clk);
      rd_start_i = 1'b0;
      if (arm_mid) begin
         repeat (3) @(negedge clk);
         arm_i = 1'b1; rd_start_i = 1'b1; post_cnt_i = '0;
         @(negedge clk);
         arm_i = 1'b0; rd_start_i = 1'b0;
      end
      repeat (n + 4) @(negedge clk);
      chk(exp_q.size() == 0, "R8 readout count", 96'(exp_q.size()), 96'd0);
      exp_q.delete();
   endtask

   // monitor: compares every streamed entry against the scoreboard
   always @(negedge clk) begin
      if (rst_n && rd_valid_o) begin
         if (exp_q.size() == 0) begin
            chk(1'b0, "R8 unexpected entry", 96'(rd_data_o), 96'd0);
         end else begin
            exp_t e;
            e = exp_q.pop_front();
            chk(rd_data_o == e.d, {cur_tag, " data"}, 96'(rd_data_o), 96'(e.d));
            chk(rd_dt_o == e.t, "R3 delta", 96'(rd_dt_o), 96'(e.t));
            chk(rd_last_o == e.last, "R8 last", 96'(rd_last_o), 96'(e.last));
         end
      end
   end

   function automatic logic [SW-1:0] smp(input logic [15:0] addr, input logic [7:0] tag);
      return {tag, 56'h0, addr} ^ {8'h0, {7{tag}}, 16'h0};
   endfunction

   int cyc = 0;
   bit finished = 1'b0;
   always @(posedge clk) begin
      cyc++;
      if (cyc > 190000 && !finished) begin
         finished = 1'b1;
         errors++;
         checks++;
         $display("FAIL watchdog: actual %0d expected below 190000", cyc);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      m_rec = 0; m_done = 0; m_trig = 0; m_full = 0; m_wp = '0;
      m_post_cfg = '0; m_post_left = '0; m_dt = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk({recording_o, done_o, full_o, rd_valid_o} == 4'b0, "R9 reset state",
          96'({recording_o, done_o, full_o, rd_valid_o}), 96'd0);

      // qualifier, trigger with post count 2
      trace_en_i = 1'b1; qual_mask_i = 4'b0011; rng_en_i = 1'b0;
      cur_tag = "R1";
      arm(2);
      chk({recording_o, done_o, full_o} == 3'b100, "R9 arm state",
          96'({recording_o, done_o, full_o}), 96'h4);
      drive(1, 4'b0001, smp(16'h0010, 8'h01), 1, 0);
      drive(1, 4'b0010, smp(16'h0020, 8'h02), 0, 0);
      drive(1, 4'b0100, smp(16'h0030, 8'h03), 1, 0);
      trace_en_i = 1'b0;
      drive(1, 4'b0001, smp(16'h0040, 8'h04), 0, 0);
      trace_en_i = 1'b1;
      drive(0, 4'b0001, smp(16'h0041, 8'h44), 1, 0);
      drive(1, 4'b0001, smp(16'h0050, 8'h05), 0, 1);
      drive(1, 4'b0001, smp(16'h0060, 8'h06), 1, 0);
      chk(done_o == 1'b0, "R4 not yet done", 96'(done_o), 96'd0);
      drive(1, 4'b0010, smp(16'h0070, 8'h07), 0, 0);
      chk(done_o == 1'b1 && recording_o == 1'b0, "R4 done after post count",
          96'({done_o, recording_o}), 96'h2);
      drive(1, 4'b0001, smp(16'h0080, 8'h08), 1, 0);
      chk(m_wp == 4'd5, "R6 model count", 96'(m_wp), 96'd5);
      readout(0);

      // wrap, full flag, oldest-first, arm during readout
      cur_tag = "R7";
      qual_mask_i = 4'b1111;
      arm(3);
      for (int i = 0; i < 21; i++)
         drive(1, 4'b0100, smp(16'(i * 3), 8'(8'h20 + i)), i[0], (i == 17));
      chk(full_o == 1'b1, "R7 full after wrap", 96'(full_o), 96'd1);
      chk(done_o == 1'b1, "R4 done after wrap", 96'(done_o), 96'd1);
      cur_tag = "R10";
      readout(1);
      chk(done_o == 1'b1 && recording_o == 1'b0, "R10 arm ignored in readout",
          96'({done_o, recording_o}), 96'h2);
      chk(full_o == 1'b1, "R10 full kept", 96'(full_o), 96'd1);

      // address window
      cur_tag = "R2";
      rng_en_i = 1'b1; rng_lo_i = 16'h0100; rng_hi_i = 16'h01FF;
      arm(1);
      chk(full_o == 1'b0, "R9 arm clears full", 96'(full_o), 96'd0);
      drive(1, 4'b0001, smp(16'h00FF, 8'h31), 0, 0);
      drive(1, 4'b0001, smp(16'h0100, 8'h32), 1, 0);
      drive(1, 4'b0001, smp(16'h01FF, 8'h33), 0, 0);
      drive(1, 4'b0001, smp(16'h0200, 8'h34), 1, 0);
      drive(1, 4'b0001, smp(16'h0150, 8'h35), 0, 1);
      drive(1, 4'b0001, smp(16'h0300, 8'h36), 0, 0);
      drive(1, 4'b0001, smp(16'h0180, 8'h37), 1, 0);
      chk(done_o == 1'b1, "R2 done on in-window sample", 96'(done_o), 96'd1);
      readout(0);
      rng_en_i = 1'b0;

      // zero post count, trigger and store in the same cycle
      cur_tag = "R5";
      arm(0);
      drive(1, 4'b0010, smp(16'h0A00, 8'h41), 0, 0);
      drive(1, 4'b0010, smp(16'h0A01, 8'h42), 1, 1);
      chk(done_o == 1'b1, "R5 done at trigger", 96'(done_o), 96'd1);
      drive(1, 4'b0010, smp(16'h0A02, 8'h43), 0, 0);
      readout(0);

      // delta saturation
      cur_tag = "R3";
      arm(1);
      drive(1, 4'b1000, smp(16'h0B00, 8'h51), 1, 0);
      tick_run(66000);
      drive(1, 4'b1000, smp(16'h0B01, 8'h52), 1, 0);
      drive(1, 4'b1000, smp(16'h0B02, 8'h53), 0, 0);
      tick_run(5);
      drive(1, 4'b1000, smp(16'h0B03, 8'h54), 0, 1);
      drive(1, 4'b1000, smp(16'h0B04, 8'h55), 1, 0);
      chk(m_ts[1] == 16'hFFFF, "R3 model saturates", 96'(m_ts[1]), 96'hFFFF);
      readout(0);

      if (!finished) begin
         finished = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule